// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit holds the two vector-length state registers of a vector-capable integer pipeline: the maximum vector length and the current vector length. Each configuration request is a single 12-bit packed field presented with a one-cycle strobe. The field always carries a new maximum length as a 5-bit immediate. It can also ask for a current length taken from an integer register, clamped to the new maximum. It can also ask for the resulting current length to be written back into an integer register.

The top bit of the field selects one of two register-specifier layouts. In the compact layout, two 3-bit fields name a destination and a source among integer registers x8 to x15. In the wide layout, one 5-bit field names a single register, and bit 5 says whether that register is read or written. One encoding is reserved and only raises a flag. The register file is reached through one combinational read port, which is used in the strobe cycle, and one write port, which is driven in the following cycle.

Top module: `vlset_unit`

## Requirements
- R1: After reset, mvl_o is 32, vl_o is 0, and rf_we_o and rsvd_o are both 0.
- R2: A strobed field of all zeros leaves mvl_o and vl_o unchanged and produces no register write.
- R3: For every strobed field that is neither all zeros nor reserved, mvl_o becomes bits 10:6 plus one (so 0 gives 1 and 31 gives 32) one clock after the strobe.
- R4: In the compact layout (bit 11 = 0), a nonzero source field in bits 2:0 of value n drives rf_raddr_o to 8+n during the strobe cycle, and vl_o becomes min(rf_rdata_i, new mvl_o). A zero source field sets vl_o to the new mvl_o.
- R5: In the compact layout, a nonzero destination field in bits 5:3 of value n writes the new vl_o to register 8+n. A zero destination field produces no write.
- R6: In the wide layout with bit 5 = 0, vl_o becomes the new mvl_o, and bits 4:0 name the destination register; it is written when nonzero and not written when zero.
- R7: In the wide layout with bit 5 = 1 and bits 4:0 nonzero, rf_raddr_o equals bits 4:0 during the strobe cycle, vl_o becomes min(rf_rdata_i, new mvl_o), and no register is written.
- R8: The wide layout with bit 5 = 1 and bits 4:0 = 0 is reserved: rsvd_o pulses high one clock after the strobe, mvl_o and vl_o stay unchanged, and nothing is written.
- R9: The state update, the write pulse and the reserved flag all appear exactly one clock after the strobe, and rf_wdata_o equals the new vl_o. Without a strobe, nothing is written, no flag is raised and the state holds.
- R10: vl_o never exceeds mvl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | One-cycle strobe qualifying cfg_field_i |
| cfg_field_i | input | 12 | Packed vector-length configuration field |
| rf_raddr_o | output | 5 | Register-file read address (0 when no read is needed) |
| rf_rdata_i | input | XLEN | Read data for rf_raddr_o, returned in the same cycle |
| rf_we_o | output | 1 | Register-file write enable, one-cycle pulse |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | XLEN | Register-file write data (new vl, zero-extended) |
| mvl_o | output | 6 | Maximum vector length, 1 to 32 |
| vl_o | output | 6 | Current vector length, 0 to 32 |
| rsvd_o | output | 1 | Pulses when a reserved encoding was strobed |

## Verification
The assertions assume that cfg_valid_i is low while reset is asserted. They also assume that rf_rdata_i settles combinationally from rf_raddr_o within the strobe cycle, and that the field is held stable for the whole strobe cycle. The bench drives every request at a falling edge and keeps it for one full cycle. Its register-file model answers reads with no delay and keeps x0 at zero. Random fields are mixed with deliberately built all-zero fields and reserved fields. Register contents are drawn both below and far above the largest legal length, so that both sides of the clamp are exercised.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
  localparam int unsigned FIELD_W   = 12;
  localparam int unsigned REG_AW    = 5;
  localparam int unsigned IMM_W     = 5;
  localparam int unsigned LEN_W     = IMM_W + 1;
  localparam int unsigned CREG_W    = 3;
  localparam int unsigned CREG_BASE = 8;

  // field bit positions
  localparam int unsigned FMT_BIT   = 11;
  localparam int unsigned IMM_LSB   = 6;
  localparam int unsigned CDST_LSB  = 3;
  localparam int unsigned CSRC_LSB  = 0;
  localparam int unsigned DIR_BIT   = 5;
  localparam int unsigned WREG_LSB  = 0;

  localparam logic [LEN_W-1:0] MVL_RST = LEN_W'(1 << IMM_W);

  typedef struct packed {
    logic              nop;
    logic              rsvd;
    logic              use_src;
    logic [REG_AW-1:0] src;
    logic              wr;
    logic [REG_AW-1:0] dst;
    logic [LEN_W-1:0]  mvl;
  } vlset_dec_t;
endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
  import vlset_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  output vlset_dec_t         dec_o
);
  logic [IMM_W-1:0]  imm;
  logic [CREG_W-1:0] cdst, csrc;
  logic [REG_AW-1:0] wreg;

  assign imm  = field_i[IMM_LSB +: IMM_W];
  assign cdst = field_i[CDST_LSB +: CREG_W];
  assign csrc = field_i[CSRC_LSB +: CREG_W];
  assign wreg = field_i[WREG_LSB +: REG_AW];

  function automatic logic [REG_AW-1:0] expand_creg(input logic [CREG_W-1:0] n);
    return REG_AW'(CREG_BASE) + REG_AW'(n);
  endfunction

  always_comb begin
    dec_o         = '0;
    dec_o.mvl     = LEN_W'(imm) + LEN_W'(1);
    if (!field_i[FMT_BIT]) begin
      dec_o.nop     = (field_i[FMT_BIT-1:0] == '0);
      dec_o.use_src = (csrc != '0);
      dec_o.src     = expand_creg(csrc);
      dec_o.wr      = (cdst != '0);
      dec_o.dst     = expand_creg(cdst);
    end else if (!field_i[DIR_BIT]) begin
      dec_o.wr      = (wreg != '0);
      dec_o.dst     = wreg;
    end else begin
      dec_o.rsvd    = (wreg == '0);
      dec_o.use_src = (wreg != '0);
      dec_o.src     = wreg;
    end
  end
endmodule

// File: rtl/vlset_clamp.sv
module vlset_clamp #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LEN_W = 6
) (
  input  logic [XLEN-1:0]  req_i,
  input  logic [LEN_W-1:0] lim_i,
  output logic [LEN_W-1:0] len_o
);
  logic [XLEN-1:0] lim_ext;
  assign lim_ext = {{(XLEN-LEN_W){1'b0}}, lim_i};
  assign len_o   = (req_i < lim_ext) ? req_i[LEN_W-1:0] : lim_i;
endmodule

// File: rtl/vlset_state.sv
module vlset_state
  import vlset_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  vlset_dec_t        dec_i,
  input  logic [LEN_W-1:0]  vl_next_i,
  output logic [LEN_W-1:0]  mvl_o,
  output logic [LEN_W-1:0]  vl_o,
  output logic              we_o,
  output logic [REG_AW-1:0] waddr_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic              rsvd_o
);
  logic upd;
  assign upd = valid_i && !dec_i.nop && !dec_i.rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mvl_o   <= MVL_RST;
      vl_o    <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
      rsvd_o  <= 1'b0;
    end else begin
      we_o   <= upd && dec_i.wr;
      rsvd_o <= valid_i && dec_i.rsvd;
      if (upd) begin
        mvl_o <= dec_i.mvl;
        vl_o  <= vl_next_i;
      end
      if (upd && dec_i.wr) begin
        waddr_o <= dec_i.dst;
        wdata_o <= XLEN'(vl_next_i);
      end
    end
  end
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vlset_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [FIELD_W-1:0] cfg_field_i,
  output logic [REG_AW-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]    rf_rdata_i,
  output logic               rf_we_o,
  output logic [REG_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic [LEN_W-1:0]   mvl_o,
  output logic [LEN_W-1:0]   vl_o,
  output logic               rsvd_o
);
  vlset_dec_t       dec;
  logic [LEN_W-1:0] clamp_len, vl_next;

  vlset_decode u_dec (
    .field_i (cfg_field_i),
    .dec_o   (dec)
  );

  assign rf_raddr_o = (cfg_valid_i && dec.use_src) ? dec.src : '0;

  vlset_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
    .req_i (rf_rdata_i),
    .lim_i (dec.mvl),
    .len_o (clamp_len)
  );

  assign vl_next = dec.use_src ? clamp_len : dec.mvl;

  vlset_state #(.XLEN(XLEN)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (cfg_valid_i),
    .dec_i     (dec),
    .vl_next_i (vl_next),
    .mvl_o     (mvl_o),
    .vl_o      (vl_o),
    .we_o      (rf_we_o),
    .waddr_o   (rf_waddr_o),
    .wdata_o   (rf_wdata_o),
    .rsvd_o    (rsvd_o)
  );
endmodule

// File: rtl/vlset_unit_chk.sv
module vlset_unit_chk
  import vlset_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_valid_i,
  input logic [FIELD_W-1:0] cfg_field_i,
  input logic [REG_AW-1:0]  rf_raddr_o,
  input logic [XLEN-1:0]    rf_rdata_i,
  input logic               rf_we_o,
  input logic [REG_AW-1:0]  rf_waddr_o,
  input logic [XLEN-1:0]    rf_wdata_o,
  input logic [LEN_W-1:0]   mvl_o,
  input logic [LEN_W-1:0]   vl_o,
  input logic               rsvd_o
);
  logic is_zero, is_rsvd, is_upd, cmp_dst;
  assign is_zero = cfg_valid_i && (cfg_field_i == '0);
  assign is_rsvd = cfg_valid_i && cfg_field_i[11] && cfg_field_i[5] && (cfg_field_i[4:0] == '0);
  assign is_upd  = cfg_valid_i && !is_zero && !is_rsvd;
  assign cmp_dst = cfg_valid_i && !cfg_field_i[11] && (cfg_field_i[5:3] != '0);

  a_r2_zero_field_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_zero |=> $stable(mvl_o) && $stable(vl_o) && !rf_we_o);

  a_r3_mvl_from_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_upd |=> mvl_o == (LEN_W'($past(cfg_field_i[10:6])) + LEN_W'(1)));

  a_r5_compact_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_dst |=> rf_we_o && (rf_waddr_o == (REG_AW'(8) + REG_AW'($past(cfg_field_i[5:3])))));

  a_r8_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rsvd |=> rsvd_o && $stable(mvl_o) && $stable(vl_o) && !rf_we_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> !rf_we_o && !rsvd_o && $stable(mvl_o) && $stable(vl_o));

  a_r9_wdata_is_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wdata_o == XLEN'(vl_o)) && (rf_waddr_o != '0));

  a_r10_vl_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o <= mvl_o);
endmodule

bind vlset_unit vlset_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .cfg_field_i (cfg_field_i),
  .rf_raddr_o  (rf_raddr_o),
  .rf_rdata_i  (rf_rdata_i),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .rf_wdata_o  (rf_wdata_o),
  .mvl_o       (mvl_o),
  .vl_o        (vl_o),
  .rsvd_o      (rsvd_o)
);

// File: tb/vlset_unit_tb_top.sv
`timescale 1ns/1ps
module vlset_unit_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [11:0]     field = '0;
  logic [4:0]      raddr, waddr;
  logic [XLEN-1:0] rdata, wdata;
  logic            we, rsvd;
  logic [5:0]      mvl, vl;

  logic [XLEN-1:0] regs [32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_mvl = 32, exp_vl = 0;

  always #2.5 clk = ~clk;

  assign rdata = regs[raddr];

  vlset_unit #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(valid), .cfg_field_i(field),
    .rf_raddr_o(raddr), .rf_rdata_i(rdata), .rf_we_o(we), .rf_waddr_o(waddr),
    .rf_wdata_o(wdata), .mvl_o(mvl), .vl_o(vl), .rsvd_o(rsvd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // reference model built from the requirements
  task automatic model(input logic [11:0] f, output bit nop, output bit rs,
                       output int ra, output bit wr, output int wa,
                       output int nmvl, output int nvl);
    int src;
    src = -1; nop = 0; rs = 0; wr = 0; wa = 0; ra = 0;
    nmvl = int'(f[10:6]) + 1;
    if (!f[11]) begin
      nop = (f[10:0] == 0);
      if (f[2:0] != 0) src = 8 + int'(f[2:0]);
      if (f[5:3] != 0) begin wr = 1; wa = 8 + int'(f[5:3]); end
    end else if (!f[5]) begin
      if (f[4:0] != 0) begin wr = 1; wa = int'(f[4:0]); end
    end else begin
      if (f[4:0] == 0) rs = 1; else src = int'(f[4:0]);
    end
    if (src >= 0) begin
      ra = src;
      nvl = (regs[src] < XLEN'(nmvl)) ? int'(regs[src]) : nmvl;
    end else nvl = nmvl;
  endtask

  // assumes call at a point after a falling edge
  task automatic do_op(input logic [11:0] f);
    bit nop, rs, wr; int ra, wa, nmvl, nvl;
    string tg;
    model(f, nop, rs, ra, wr, wa, nmvl, nvl);
    tg = f[11] ? (f[5] ? "R7" : "R6") : "R4";
    valid = 1'b1; field = f;
    #1;
    chk(raddr == 5'(ra), tg, "read address", raddr, ra);
    @(negedge clk);
    valid = 1'b0; field = $urandom;
    #1;
    if (nop || rs) begin
      chk(mvl == 6'(exp_mvl), nop ? "R2" : "R8", "mvl held", mvl, exp_mvl);
      chk(vl == 6'(exp_vl), nop ? "R2" : "R8", "vl held", vl, exp_vl);
      chk(we == 1'b0, nop ? "R2" : "R8", "no write", we, 0);
    end else begin
      exp_mvl = nmvl; exp_vl = nvl;
      chk(mvl == 6'(nmvl), "R3", "mvl", mvl, nmvl);
      chk(vl == 6'(nvl), tg, "vl", vl, nvl);
      chk(we == wr, f[11] ? "R6" : "R5", "write enable", we, wr);
      if (wr) begin
        chk(waddr == 5'(wa), f[11] ? "R6" : "R5", "write address", waddr, wa);
        chk(wdata == XLEN'(nvl), "R9", "write data", wdata, nvl);
        regs[wa] = XLEN'(nvl);
      end
    end
    chk(rsvd == rs, "R8", "reserved flag", rsvd, rs);
    chk(vl <= mvl, "R10", "vl bound", vl, mvl);
  endtask

  task automatic idle_check();
    @(negedge clk); #1;
    chk(we == 1'b0 && rsvd == 1'b0, "R9", "idle pulses", {we, rsvd}, 0);
    chk(mvl == 6'(exp_mvl) && vl == 6'(exp_vl), "R9", "idle state",
        {mvl, vl}, {6'(exp_mvl), 6'(exp_vl)});
  endtask

  task automatic shuffle_regs();
    regs[0] = '0;
    for (int i = 1; i < 32; i++)
      regs[i] = ($urandom % 4 == 0) ? $urandom : ($urandom % 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) regs[i] = XLEN'(i * 3);
    regs[0] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(mvl == 6'd32 && vl == 6'd0, "R1", "reset lengths", {mvl, vl}, {6'd32, 6'd0});
    chk(we == 1'b0 && rsvd == 1'b0, "R1", "reset pulses", {we, rsvd}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // directed corners
    do_op(12'h000);                                   // R2 all-zero
    regs[9] = 32'd1000;
    do_op({1'b0, 5'd31, 3'd0, 3'd1});                 // R4 clamp to 32
    regs[10] = 32'd3;
    do_op({1'b0, 5'd15, 3'd2, 3'd2});                 // R4/R5 read x10, write x10
    regs[11] = 32'd0;
    do_op({1'b0, 5'd7, 3'd7, 3'd3});                  // R4 zero request
    do_op({1'b0, 5'd0, 3'd5, 3'd0});                  // R3 imm 0 -> 1, R5
    do_op({1'b1, 5'd20, 1'b0, 5'd0});                 // R6 dest x0, no write
    do_op({1'b1, 5'd9, 1'b0, 5'd5});                  // R6 write x5
    do_op({1'b1, 5'd12, 1'b1, 5'd0});                 // R8 reserved
    idle_check();
    regs[17] = 32'hFFFF_FFFF;
    do_op({1'b1, 5'd4, 1'b1, 5'd17});                 // R7 large request
    regs[18] = 32'd2;
    do_op({1'b1, 5'd30, 1'b1, 5'd18});                // R7 small request
    do_op(12'h000);                                   // R2 after changes
    idle_check();

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [11:0] f;
      if (n % 25 == 0) shuffle_regs();
      f = 12'($urandom);
      case ($urandom % 16)
        0: f = '0;
        1: f = {1'b1, f[10:6], 1'b1, 5'd0};
        default: ;
      endcase
      do_op(f);
      if ($urandom % 8 == 0) idle_check();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule